// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder/Subtractor

This block adds or subtracts two 32-bit two's-complement operands and presents the result, the carry-out and a signed overflow flag on registered outputs one clock after the operands are sampled. A single mode input chooses the operation. In subtract mode the second operand is inverted bit by bit and the mode bit enters as the carry-in, so A - B is formed as A + ~B + 1 on the same datapath.

The carry network is hierarchical rather than a rippling chain. Each bit cell produces a propagate term (the XOR of its operand bits) and a generate term (their AND), and forms its sum bit as the propagate XORed with its incoming carry. A first-level lookahead unit over each 4-bit group derives the group's internal carries from the bit terms and the group carry-in, and reduces them to one group propagate and one group generate. A second-level lookahead unit in each 16-bit section does the same over the four group pairs to produce the group carry-ins and the section carry-out. The section carry-out of the low half is the carry-in of the high half. Overflow is the XOR of the carry into the most significant bit and the carry out of it.

Top module: `cla_addsub`

## Requirements
- R1: The outputs `sum_o`, `cout_o` and `ovf_o` are registered: operands and mode sampled at one rising clock edge appear on the outputs right after that same edge and hold until the next edge.
- R2: With `sub_i` = 0, `sum_o` equals (A + B) modulo 2^32 and `cout_o` is bit 32 of the unsigned 33-bit sum.
- R3: `ovf_o` is 1 exactly when the signed result is out of range: in add mode when A and B share a sign bit and `sum_o` has the other one; in subtract mode when A and B differ in sign and the sign of `sum_o` differs from that of A.
- R4: With `sub_i` = 1, `sum_o` equals (A - B) modulo 2^32 and `cout_o` is bit 32 of A + ~B + 1, which is 1 exactly when A is greater than or equal to B as unsigned values (no borrow).
- R5: A synchronous active-high `rst` clears `sum_o`, `cout_o` and `ovf_o` to 0 at the next rising edge.
- R6: A carry generated in bit 0 propagates through every group and both sections: 0xFFFFFFFF + 1 gives a sum of 0, carry-out 1 and no overflow.
- R7: A carry leaving the top group of the low 16-bit section enters the high section: 0x0000FFFF + 1 gives 0x00010000 with carry-out 0, and a carry leaving bit 3 enters the second group: 0x0000000F + 1 gives 0x00000010.
- R8: Subtracting equal operands gives a sum of 0, carry-out 1 and no overflow; subtracting 1 from 0x80000000 gives 0x7FFFFFFF with overflow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts `b_i` from `a_i` |
| sum_o | output | 32 | Registered result modulo 2^32 |
| cout_o | output | 1 | Registered carry out of the most significant bit |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The bench aims at the carry paths that a hierarchical lookahead can break: a carry crossing a 4-bit group edge, one crossing the 16-bit section edge, and one running the whole width, where a wrong group generate or a missing section link would drop a carry and give 0x00000000 instead of 0x00010000 or lose the final carry-out. Subtraction of equal values and of 1 from the most negative value check that the mode bit really feeds the carry-in and that overflow uses the MSB carries; a design that forgot the carry-in would be off by one, and one that took overflow from the sign bits of the wrong operand would flag the wrong cases. A pseudo-random sweep in both modes compares every output against a behavioural 33-bit reference.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned GROUP_W = 4;
  localparam int unsigned GROUPS  = 4;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N-1:0] c,
  output logic         gp,
  output logic         gg,
  output logic         cout
);
  // Sum-of-products carries: every carry is formed from the bit terms
  // and cin directly, with no dependence on the carry of its neighbour.
  always_comb begin : la_terms
    logic acc;
    logic prod;
    c = '0;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        prod = g[j];
        for (int k = j + 1; k < i; k++) prod = prod & p[k];
        acc = acc | prod;
      end
      prod = cin;
      for (int k = 0; k < i; k++) prod = prod & p[k];
      c[i] = acc | prod;
    end
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = g[j];
      for (int k = j + 1; k < N; k++) prod = prod & p[k];
      acc = acc | prod;
    end
    gg   = acc;
    gp   = &p;
    cout = gg | (gp & cin);
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic [N-1:0] c,
  output logic         gp,
  output logic         gg
);
  logic [N-1:0] p;
  logic [N-1:0] g;
  logic         unused_cout;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign p[i] = a[i] ^ b[i];
    assign g[i] = a[i] & b[i];
    assign s[i] = p[i] ^ c[i];
  end

  cla_lookahead #(.N(N)) u_la (
    .p(p), .g(g), .cin(cin), .c(c), .gp(gp), .gg(gg), .cout(unused_cout)
  );
endmodule

// File: rtl/cla_section.sv
module cla_section #(
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4,
  localparam int unsigned SW = GW * NG
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] s,
  output logic [SW-1:0] c,
  output logic          cout
);
  logic [NG-1:0] grp_p;
  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_cin;
  logic          sec_p;
  logic          sec_g;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_group #(.N(GW)) u_grp (
      .a(a[k*GW +: GW]), .b(b[k*GW +: GW]), .cin(grp_cin[k]),
      .s(s[k*GW +: GW]), .c(c[k*GW +: GW]), .gp(grp_p[k]), .gg(grp_g[k])
    );
  end

  cla_lookahead #(.N(NG)) u_la2 (
    .p(grp_p), .g(grp_g), .cin(cin), .c(grp_cin),
    .gp(sec_p), .gg(sec_g), .cout(cout)
  );
endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned GW    = GROUP_W,
  parameter int unsigned NG    = GROUPS,
  localparam int unsigned SW   = GW * NG,
  localparam int unsigned NSEC = WIDTH / SW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] s_w;
  logic [WIDTH-1:0] c_w;
  logic [NSEC:0]    link;

  assign b_eff   = b_i ^ {WIDTH{sub_i}};
  assign link[0] = sub_i;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    cla_section #(.GW(GW), .NG(NG)) u_sec (
      .a(a_i[k*SW +: SW]), .b(b_eff[k*SW +: SW]), .cin(link[k]),
      .s(s_w[k*SW +: SW]), .c(c_w[k*SW +: SW]), .cout(link[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      sum_o  <= s_w;
      cout_o <= link[NSEC];
      ovf_o  <= c_w[WIDTH-1] ^ link[NSEC];
    end
  end
endmodule

// File: rtl/cla_addsub_chk.sv
module cla_addsub_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             ovf_o
);
  logic [WIDTH:0]   ref_full;
  logic [WIDTH-1:0] ref_b;
  logic             ref_ovf;

  assign ref_b    = sub_i ? ~b_i : b_i;
  assign ref_full = {1'b0, a_i} + {1'b0, ref_b} + {{WIDTH{1'b0}}, sub_i};
  assign ref_ovf  = (a_i[WIDTH-1] == ref_b[WIDTH-1]) &&
                    (ref_full[WIDTH-1] != a_i[WIDTH-1]);

  // R2: addition result and carry
  assert_add_R2: assert property (@(posedge clk) disable iff (rst)
    !sub_i |=> {cout_o, sum_o} == $past(ref_full));

  // R4: subtraction result and no-borrow carry
  assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
    sub_i |=> {cout_o, sum_o} == $past(ref_full));

  // R3: signed overflow
  assert_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ovf_o == $past(ref_ovf));

  // R5: reset clears outputs
  assert_reset_R5: assert property (@(posedge clk)
    rst |=> (sum_o == '0) && !cout_o && !ovf_o);

  // R1: outputs only move at the edge following a sample; they stay stable
  // when the sampled operands do not change
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ($stable(a_i) && $stable(b_i) && $stable(sub_i) && !$past(rst))
      |=> $stable(sum_o));
endmodule

bind cla_addsub cla_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
  .sum_o(sum_o), .cout_o(cout_o), .ovf_o(ovf_o)
);

// File: tb/cla_addsub_test.sv
module cla_addsub_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         sub = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cla_addsub uut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at negedge, capture at posedge, observe at the next negedge
  task automatic run_op(input string req, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic s);
    logic [W-1:0] yb;
    logic [W:0]   full;
    logic         eovf;
    @(negedge clk);
    a = x; b = y; sub = s;
    yb   = s ? ~y : y;
    full = {1'b0, x} + {1'b0, yb} + {{W{1'b0}}, s};
    if (s) eovf = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
    else   eovf = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
    @(negedge clk);
    check(req, {ovf, cout, sum}, {eovf, full[W], full[W-1:0]});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a = 32'hFFFF_FFFF; b = 32'h1; sub = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 reset", {ovf, cout, sum}, '0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    @(negedge clk);
    a = 32'h0000_1234; b = 32'h0000_0001; sub = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after edge", {ovf, cout, sum}, {2'b00, 32'h0000_1235});
    @(negedge clk);
    a = 32'h0000_0010;
    #2;
    check("R1 held until edge", {ovf, cout, sum}, {2'b00, 32'h0000_1235});
    @(negedge clk);
    check("R1 next edge", {ovf, cout, sum}, {2'b00, 32'h0000_0011});
  endtask

  task automatic t_add();
    run_op("R2 add small", 32'd100, 32'd23, 1'b0);
    run_op("R2 add carry-out", 32'hF000_0000, 32'h2000_0001, 1'b0);
  endtask

  task automatic t_ovf();
    run_op("R3 add pos ovf", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    run_op("R3 add neg ovf", 32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op("R3 sub ovf", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_op("R3 no ovf mixed", 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_sub();
    run_op("R4 sub borrow", 32'd5, 32'd9, 1'b1);
    run_op("R4 sub no borrow", 32'd9, 32'd5, 1'b1);
  endtask

  task automatic t_chain();
    @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'h1; sub = 1'b0;
    @(negedge clk);
    check("R6 full chain", {ovf, cout, sum}, {2'b01, 32'h0});
  endtask

  task automatic t_boundaries();
    @(negedge clk);
    a = 32'h0000_FFFF; b = 32'h1; sub = 1'b0;
    @(negedge clk);
    check("R7 section edge", {ovf, cout, sum}, {2'b00, 32'h0001_0000});
    a = 32'h0000_000F;
    @(negedge clk);
    check("R7 group edge", {ovf, cout, sum}, {2'b00, 32'h0000_0010});
  endtask

  task automatic t_sub_corners();
    @(negedge clk);
    a = 32'hDEAD_BEEF; b = 32'hDEAD_BEEF; sub = 1'b1;
    @(negedge clk);
    check("R8 equal sub", {ovf, cout, sum}, {2'b01, 32'h0});
    a = 32'h8000_0000; b = 32'h1;
    @(negedge clk);
    check("R8 min minus one", {ovf, cout, sum}, {2'b11, 32'h7FFF_FFFF});
  endtask

  task automatic t_sweep();
    logic [W-1:0] st = 32'h1357_9BDF;
    logic [W-1:0] x;
    for (int i = 0; i < 200; i++) begin
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      x  = st;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      run_op(i[0] ? "R4 sweep sub" : "R2 sweep add", x, st, i[0]);
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_add();
    t_ovf();
    t_sub();
    t_chain();
    t_boundaries();
    t_sub_corners();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule